// File: doc/BRIEF.md
# I2C Target Acknowledge and Status Controller

This block holds the per-byte acknowledge and status logic of an I2C target. It watches the already synchronized SCL and SDA lines, finds start and stop conditions, and counts the clock pulses of each byte. In the ninth clock slot it pulls SDA low or leaves it released. The choice comes from two control bits: one applies once the remaining-byte counter has reached zero, the other applies to every other case. A bus-error input overrides both and forces a NACK.

For bytes the target sends, the block records the acknowledge that the host returned. When the receive buffer is still full as a new byte lands, or the transmit buffer is empty when a read byte is due, the block does one of two things:
- With stretching enabled, it raises a clock-hold request.
- With stretching disabled, it sets a sticky overflow or underflow flag.

Address decoding stays outside the block. It reports a match with a single pulse during the address byte. The data shift registers are also outside.

Top module: `i2c_tgt_ack_status`

## Requirements
- R1: After a synchronous reset, sda_drive_low, ack_window, ack_status, stretch_req, rx_ovf and tx_unf are all 0.
- R2: An address byte that saw an addr_match pulse is acknowledged with the level ack_dat_nack gives: 0 pulls SDA low (ACK) and 1 leaves it released (NACK). An address byte without a match leaves SDA released, both in its slot and for the data bytes that follow it.
- R3: A write data byte to a selected target is acknowledged by ack_cnt_nack when byte_cnt is zero and by ack_dat_nack when byte_cnt is non-zero. For both bits, 1 means NACK and 0 means ACK.
- R4: While bus_err is 1 at the moment of the acknowledge decision, SDA stays released (NACK) whatever the control bits say.
- R5: ack_window rises after the 8th falling SCL edge of a byte and falls after the 9th rising edge. SDA is pulled only inside that window and is released at the next falling edge.
- R6: For a data byte the target transmits, ack_status takes the SDA level at the 9th rising edge: 1 when the host returned NACK, 0 when it returned ACK. Only the latest byte is kept.
- R7: With no_stretch at 1, a write data byte that completes while rx_full is 1 sets rx_ovf. The flag stays set until an ovf_clr pulse clears it.
- R8: With no_stretch at 1, tx_unf is set at the end of an acknowledge slot that makes a read byte due while tx_empty is 1. A read byte is due after a matched, ACKed read address, or after a read byte that the host ACKed. The flag stays set until an unf_clr pulse clears it.
- R9: With no_stretch at 0, the two conditions of R7 and R8 set stretch_req instead, and rx_ovf and tx_unf stay 0. stretch_req holds until a stretch_rel pulse. With no_stretch at 1, stretch_req never rises.
- R10: A start or repeated start (SDA falling while SCL is high) restarts the bit count, so the next byte is taken as an address byte counted from its first bit.
- R11: A stop (SDA rising while SCL is high) clears ack_window, releases SDA and deselects the target. Bytes clocked after a stop and before the next start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (bus value) |
| addr_match | input | 1 | One-cycle pulse from the address decoder during an address byte |
| byte_cnt | input | CNT_W | Remaining-byte counter value |
| rx_full | input | 1 | Receive buffer holds unread data |
| tx_empty | input | 1 | Transmit buffer has no data |
| ack_cnt_nack | input | 1 | Acknowledge level used when byte_cnt is zero (1 = NACK) |
| ack_dat_nack | input | 1 | Acknowledge level for addresses and for non-zero byte_cnt (1 = NACK) |
| no_stretch | input | 1 | 1 disables clock stretching and enables the overflow/underflow flags |
| bus_err | input | 1 | Bus error present; forces NACK |
| stretch_rel | input | 1 | Pulse that drops stretch_req |
| ovf_clr | input | 1 | Write-one-to-clear strobe for rx_ovf |
| unf_clr | input | 1 | Write-one-to-clear strobe for tx_unf |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| ack_window | output | 1 | Acknowledge slot in progress |
| ack_status | output | 1 | Host acknowledge of the last transmitted byte (1 = NACK) |
| stretch_req | output | 1 | Request to hold SCL low |
| rx_ovf | output | 1 | Sticky receive-overflow flag |
| tx_unf | output | 1 | Sticky transmit-underflow flag |

## Verification
The bench builds the block with CNT_W = 3. Random draws of byte_cnt then land on zero, on small non-zero values and on the all-ones count often, so both acknowledge sources get exercised on the same short bus traffic. BITS_PER_BYTE stays at 8, so the bench's bit-level host model produces real I2C framing. That framing covers repeated starts in the middle of a byte, stops after an acknowledged address, and read transfers whose host acknowledge feeds the underflow path.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_ADDR = 2'd1,
    BK_DATA = 2'd2
  } byte_kind_t;

  // 1 = pull SDA low (ACK); a NACK request or a bus error releases it
  function automatic logic ack_pull_level(input logic nack_req, input logic err);
    return !(nack_req || err);
  endfunction

endpackage

// File: rtl/i2c_line_edges.sv
module i2c_line_edges (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);

  logic scl_q, scl_qq, sda_q, sda_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      scl_qq <= 1'b1;
      sda_q  <= 1'b1;
      sda_qq <= 1'b1;
    end else begin
      scl_q  <= scl_i;
      scl_qq <= scl_q;
      sda_q  <= sda_i;
      sda_qq <= sda_q;
    end
  end

  always_comb begin
    scl_rise  = scl_q && !scl_qq;
    scl_fall  = !scl_q && scl_qq;
    start_det = scl_q && scl_qq && sda_qq && !sda_q;
    stop_det  = scl_q && scl_qq && !sda_qq && sda_q;
    sda_lvl   = sda_q;
  end

endmodule

// File: rtl/i2c_bit_track.sv
module i2c_bit_track #(
  parameter int BITS_PER_BYTE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  output logic ack_window,
  output logic byte_done,
  output logic ack_rise,
  output logic ack_end,
  output logic last_bit_rise
);

  localparam int BIT_W = $clog2(BITS_PER_BYTE + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_BYTE);
  localparam logic [BIT_W-1:0] PRE_LAST = BIT_W'(BITS_PER_BYTE - 1);

  logic [BIT_W-1:0] bit_cnt;
  logic             ack_tail;

  always_comb begin
    byte_done     = scl_fall && (bit_cnt == LAST_BIT) && !ack_window;
    ack_rise      = scl_rise && ack_window;
    ack_end       = scl_fall && ack_tail;
    last_bit_rise = scl_rise && !ack_window && (bit_cnt == PRE_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      ack_window <= 1'b0;
      ack_tail   <= 1'b0;
    end else if (start_det || stop_det) begin
      bit_cnt    <= '0;
      ack_window <= 1'b0;
      ack_tail   <= 1'b0;
    end else begin
      if (ack_rise) begin
        bit_cnt    <= '0;
        ack_window <= 1'b0;
        ack_tail   <= 1'b1;
      end else if (scl_rise && bit_cnt != LAST_BIT) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (byte_done) ack_window <= 1'b1;
      if (scl_fall)  ack_tail   <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl
  import i2c_ack_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_lvl,
  input  logic             byte_done,
  input  logic             ack_rise,
  input  logic             ack_end,
  input  logic             last_bit_rise,
  input  logic             addr_match,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             rx_full,
  input  logic             tx_empty,
  input  logic             ack_cnt_nack,
  input  logic             ack_dat_nack,
  input  logic             no_stretch,
  input  logic             bus_err,
  input  logic             stretch_rel,
  input  logic             ovf_clr,
  input  logic             unf_clr,
  output logic             sda_pull,
  output logic             ack_status,
  output logic             stretch_req,
  output logic             rx_ovf,
  output logic             tx_unf
);

  byte_kind_t kind;
  logic       sel, matched, rd_mode;
  logic       cnt_zero, data_nack, tx_due;

  always_comb begin
    cnt_zero  = (byte_cnt == '0);
    data_nack = cnt_zero ? ack_cnt_nack : ack_dat_nack;
    tx_due    = sel && rd_mode && ((kind == BK_ADDR) ? sda_pull : !ack_status);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind        <= BK_IDLE;
      sel         <= 1'b0;
      matched     <= 1'b0;
      rd_mode     <= 1'b0;
      sda_pull    <= 1'b0;
      ack_status  <= 1'b0;
      stretch_req <= 1'b0;
      rx_ovf      <= 1'b0;
      tx_unf      <= 1'b0;
    end else begin
      // clears first so that a same-cycle set wins
      if (stretch_rel) stretch_req <= 1'b0;
      if (ovf_clr)     rx_ovf      <= 1'b0;
      if (unf_clr)     tx_unf      <= 1'b0;

      if (start_det) begin
        kind     <= BK_ADDR;
        matched  <= 1'b0;
        sel      <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        kind     <= BK_IDLE;
        sel      <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        if (addr_match && kind == BK_ADDR) matched <= 1'b1;
        if (last_bit_rise && kind == BK_ADDR) rd_mode <= sda_lvl;

        if (byte_done) begin
          if (kind == BK_ADDR) begin
            if (matched || addr_match) begin
              sel      <= 1'b1;
              sda_pull <= ack_pull_level(ack_dat_nack, bus_err);
            end
          end else if (kind == BK_DATA && sel && !rd_mode) begin
            sda_pull <= ack_pull_level(data_nack, bus_err);
            if (rx_full) begin
              if (no_stretch) rx_ovf      <= 1'b1;
              else            stretch_req <= 1'b1;
            end
          end
        end

        if (ack_rise && kind == BK_DATA && sel && rd_mode) ack_status <= sda_lvl;

        if (ack_end) begin
          sda_pull <= 1'b0;
          if (kind == BK_ADDR) begin
            kind <= BK_DATA;
            if (!sda_pull) sel <= 1'b0;
          end
          if (tx_due && tx_empty) begin
            if (no_stretch) tx_unf      <= 1'b1;
            else            stretch_req <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/i2c_tgt_ack_status.sv
module i2c_tgt_ack_status #(
  parameter int CNT_W         = 8,
  parameter int BITS_PER_BYTE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_match,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             rx_full,
  input  logic             tx_empty,
  input  logic             ack_cnt_nack,
  input  logic             ack_dat_nack,
  input  logic             no_stretch,
  input  logic             bus_err,
  input  logic             stretch_rel,
  input  logic             ovf_clr,
  input  logic             unf_clr,
  output logic             sda_drive_low,
  output logic             ack_window,
  output logic             ack_status,
  output logic             stretch_req,
  output logic             rx_ovf,
  output logic             tx_unf
);

  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic byte_done, ack_rise, ack_end, last_bit_rise;

  i2c_line_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_lvl   (sda_lvl)
  );

  i2c_bit_track #(.BITS_PER_BYTE(BITS_PER_BYTE)) u_track (
    .clk           (clk),
    .rst           (rst),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .ack_window    (ack_window),
    .byte_done     (byte_done),
    .ack_rise      (ack_rise),
    .ack_end       (ack_end),
    .last_bit_rise (last_bit_rise)
  );

  i2c_ack_ctrl #(.CNT_W(CNT_W)) u_ack (
    .clk           (clk),
    .rst           (rst),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sda_lvl       (sda_lvl),
    .byte_done     (byte_done),
    .ack_rise      (ack_rise),
    .ack_end       (ack_end),
    .last_bit_rise (last_bit_rise),
    .addr_match    (addr_match),
    .byte_cnt      (byte_cnt),
    .rx_full       (rx_full),
    .tx_empty      (tx_empty),
    .ack_cnt_nack  (ack_cnt_nack),
    .ack_dat_nack  (ack_dat_nack),
    .no_stretch    (no_stretch),
    .bus_err       (bus_err),
    .stretch_rel   (stretch_rel),
    .ovf_clr       (ovf_clr),
    .unf_clr       (unf_clr),
    .sda_pull      (sda_drive_low),
    .ack_status    (ack_status),
    .stretch_req   (stretch_req),
    .rx_ovf        (rx_ovf),
    .tx_unf        (tx_unf)
  );

endmodule

// File: rtl/i2c_tgt_ack_status_chk.sv
module i2c_tgt_ack_status_chk (
  input logic clk,
  input logic rst,
  input logic bus_err,
  input logic no_stretch,
  input logic ovf_clr,
  input logic unf_clr,
  input logic sda_drive_low,
  input logic ack_window,
  input logic stretch_req,
  input logic rx_ovf,
  input logic tx_unf
);

  AST_PULL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> ack_window); // R5

  AST_NACK_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !$past(bus_err)); // R4

  AST_OVF_NEEDS_NOSTRETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovf) |-> $past(no_stretch)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_ovf && !ovf_clr) |=> rx_ovf); // R7

  AST_UNF_NEEDS_NOSTRETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_unf) |-> $past(no_stretch)); // R8

  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_unf && !unf_clr) |=> tx_unf); // R8

  AST_NO_STRETCH_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(stretch_req) |-> !$past(no_stretch)); // R9

endmodule

bind i2c_tgt_ack_status i2c_tgt_ack_status_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_err       (bus_err),
  .no_stretch    (no_stretch),
  .ovf_clr       (ovf_clr),
  .unf_clr       (unf_clr),
  .sda_drive_low (sda_drive_low),
  .ack_window    (ack_window),
  .stretch_req   (stretch_req),
  .rx_ovf        (rx_ovf),
  .tx_unf        (tx_unf)
);

// File: tb/test_i2c_tgt_ack_status.sv
`timescale 1ns/1ps
module test_i2c_tgt_ack_status;

  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_host = 1'b1;
  logic addr_match = 1'b0;
  logic [CNT_W-1:0] byte_cnt = '0;
  logic rx_full = 1'b0, tx_empty = 1'b0;
  logic ack_cnt_nack = 1'b0, ack_dat_nack = 1'b0;
  logic no_stretch = 1'b1, bus_err = 1'b0;
  logic stretch_rel = 1'b0, ovf_clr = 1'b0, unf_clr = 1'b0;
  logic sda_drive_low, ack_window, ack_status, stretch_req, rx_ovf, tx_unf;
  logic sda_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_host & ~sda_drive_low;

  i2c_tgt_ack_status #(.CNT_W(CNT_W), .BITS_PER_BYTE(8)) i_i2c_tgt_ack_status (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .addr_match(addr_match),
    .byte_cnt(byte_cnt), .rx_full(rx_full), .tx_empty(tx_empty),
    .ack_cnt_nack(ack_cnt_nack), .ack_dat_nack(ack_dat_nack), .no_stretch(no_stretch),
    .bus_err(bus_err), .stretch_rel(stretch_rel), .ovf_clr(ovf_clr), .unf_clr(unf_clr),
    .sda_drive_low(sda_drive_low), .ack_window(ack_window), .ack_status(ack_status),
    .stretch_req(stretch_req), .rx_ovf(rx_ovf), .tx_unf(tx_unf));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_host = 1'b1; wclk(4);
    scl = 1'b1;      wclk(4);
    sda_host = 1'b0; wclk(4);
    scl = 1'b0;      wclk(4);
  endtask

  task automatic do_stop();
    sda_host = 1'b0; wclk(4);
    scl = 1'b1;      wclk(4);
    sda_host = 1'b1; wclk(4);
  endtask

  task automatic bit_out(input logic b);
    sda_host = b; wclk(4);
    scl = 1'b1;   wclk(4);
    scl = 1'b0;   wclk(2);
  endtask

  task automatic send_bits(input logic [7:0] d, input int nbits, input bit match);
    for (int i = 0; i < nbits; i++) begin
      bit_out(d[7-i]);
      if (match && i == 3) begin
        addr_match = 1'b1; wclk(1); addr_match = 1'b0;
      end
    end
  endtask

  task automatic ack_open(input logic host_bit);
    sda_host = host_bit; wclk(4);
  endtask
  task automatic ack_hi();
    scl = 1'b1; wclk(4);
  endtask
  task automatic ack_lo();
    scl = 1'b0; wclk(4);
  endtask

  function automatic logic exp_pull(input logic [CNT_W-1:0] c, input logic ac,
                                    input logic ad, input logic be);
    logic lvl;
    lvl = (c == '0) ? ac : ad;
    return !(lvl || be);
  endfunction

  task automatic wr_addr(input bit match);
    do_start();
    send_bits({7'h2A, 1'b0}, 8, match);
    ack_open(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic exp_ovf;
    void'($urandom(32'd4711));
    wclk(5); rst = 1'b0; wclk(3);
    // R1 reset state
    chk("R1 pull", sda_drive_low, 0);
    chk("R1 window", ack_window, 0);
    chk("R1 status", ack_status, 0);
    chk("R1 stretch", stretch_req, 0);
    chk("R1 ovf", rx_ovf, 0);
    chk("R1 unf", tx_unf, 0);

    // R2/R5: matched address, ACK
    ack_dat_nack = 0;
    wr_addr(1);
    chk("R2 addr ack pull", sda_drive_low, 1);
    chk("R5 window set", ack_window, 1);
    ack_hi();
    chk("R5 window clear at 9th rise", ack_window, 0);
    chk("R5 pull held high phase", sda_drive_low, 1);
    ack_lo();
    chk("R5 released after slot", sda_drive_low, 0);

    // R3 nonzero count uses ack_dat_nack
    byte_cnt = 3'd3; ack_dat_nack = 1; ack_cnt_nack = 0;
    send_bits(8'h5C, 8, 0); ack_open(1);
    chk("R3 nonzero cnt NACK", sda_drive_low, 0);
    ack_hi(); ack_lo();
    byte_cnt = 3'd0;
    send_bits(8'hA3, 8, 0); ack_open(1);
    chk("R3 zero cnt ACK", sda_drive_low, 1);
    ack_hi(); ack_lo();
    // R4 bus error forces NACK
    bus_err = 1;
    send_bits(8'h11, 8, 0); ack_open(1);
    chk("R4 bus error NACK", sda_drive_low, 0);
    ack_hi(); ack_lo(); bus_err = 0;

    // R7 overflow with no_stretch=1, sticky, clear
    rx_full = 1; no_stretch = 1;
    send_bits(8'h77, 8, 0); ack_open(1);
    chk("R7 ovf set", rx_ovf, 1);
    chk("R9 no stretch when off", stretch_req, 0);
    ack_hi(); ack_lo(); rx_full = 0;
    send_bits(8'h01, 8, 0); ack_open(1); ack_hi(); ack_lo();
    chk("R7 ovf sticky", rx_ovf, 1);
    ovf_clr = 1; wclk(1); ovf_clr = 0; wclk(1);
    chk("R7 ovf cleared", rx_ovf, 0);

    // R9 stretch instead of overflow
    no_stretch = 0; rx_full = 1;
    send_bits(8'h3C, 8, 0); ack_open(1);
    chk("R9 stretch on rx full", stretch_req, 1);
    chk("R9 ovf stays 0", rx_ovf, 0);
    ack_hi(); ack_lo(); rx_full = 0;
    stretch_rel = 1; wclk(1); stretch_rel = 0; wclk(1);
    chk("R9 stretch released", stretch_req, 0);
    no_stretch = 1;

    // R11 stop deselects
    do_stop();
    chk("R11 window after stop", ack_window, 0);
    chk("R11 pull after stop", sda_drive_low, 0);
    scl = 0; wclk(4);
    ack_dat_nack = 0; byte_cnt = 3'd2;
    send_bits(8'hFF, 8, 0); ack_open(1);
    chk("R11 no ack after stop", sda_drive_low, 0);
    ack_hi(); ack_lo();

    // R2 unmatched address
    wr_addr(0);
    chk("R2 unmatched addr released", sda_drive_low, 0);
    ack_hi(); ack_lo();
    send_bits(8'h42, 8, 0); ack_open(1);
    chk("R2 unmatched data released", sda_drive_low, 0);
    ack_hi(); ack_lo();

    // R10 repeated start mid byte
    do_start();
    send_bits(8'hE0, 3, 0);
    do_start();
    send_bits({7'h2A, 1'b0}, 5, 1);
    chk("R10 no early window", ack_window, 0);
    send_bits({3'b0, 5'b01000}, 3, 0);
    ack_open(1);
    chk("R10 ack after restart", sda_drive_low, 1);
    ack_hi(); ack_lo();

    // R8 underflow on read, R6 host ack capture
    tx_empty = 1; no_stretch = 1;
    do_start();
    send_bits({7'h2A, 1'b1}, 8, 1); ack_open(1);
    chk("R2 read addr ack", sda_drive_low, 1);
    ack_hi(); ack_lo();
    chk("R8 unf set", tx_unf, 1);
    tx_empty = 0;
    send_bits(8'hFF, 8, 0); ack_open(1); ack_hi();
    chk("R6 host NACK", ack_status, 1);
    ack_lo();
    chk("R8 unf sticky", tx_unf, 1);
    send_bits(8'hFF, 8, 0); ack_open(0); ack_hi();
    chk("R6 host ACK", ack_status, 0);
    ack_lo();
    unf_clr = 1; wclk(1); unf_clr = 0; wclk(1);
    chk("R8 unf cleared", tx_unf, 0);

    // R9 stretch on read underflow
    no_stretch = 0; tx_empty = 1;
    do_start();
    send_bits({7'h2A, 1'b1}, 8, 1); ack_open(1); ack_hi(); ack_lo();
    chk("R9 stretch on tx empty", stretch_req, 1);
    chk("R9 unf stays 0", tx_unf, 0);
    stretch_rel = 1; wclk(1); stretch_rel = 0; wclk(1);
    tx_empty = 0; no_stretch = 1;
    do_stop(); scl = 0; wclk(2);

    // random write bytes: R3/R4/R7
    ack_dat_nack = 0; bus_err = 0;
    wr_addr(1); ack_hi(); ack_lo();
    exp_ovf = 0;
    for (int k = 0; k < 40; k++) begin
      byte_cnt     = CNT_W'($urandom % 8);
      if (k % 4 == 0) byte_cnt = '0;
      ack_cnt_nack = 1'($urandom % 2);
      ack_dat_nack = 1'($urandom % 2);
      bus_err      = (($urandom % 8) == 0);
      rx_full      = (($urandom % 5) == 0);
      exp_ovf      = exp_ovf | rx_full;
      send_bits(8'($urandom), 8, 0); ack_open(1);
      chk("R3 random ack level", sda_drive_low,
          exp_pull(byte_cnt, ack_cnt_nack, ack_dat_nack, bus_err));
      chk("R7 random ovf", rx_ovf, exp_ovf);
      ack_hi(); ack_lo();
    end
    bus_err = 0; rx_full = 0;
    do_stop();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule